// File: doc/BRIEF.md
# Temporary Bus Master Takeover Controller

This block lets a second processor board sit on a shared parallel bus without driving it until software on the current bus owner hands the bus over. The current owner writes to an 8-bit output port whose address is a configuration input. One data bit of that write, chosen by a bit-select input, is compared with a configurable active level. A match pulls a latched request output low. If the bit is written with the opposite value, the request output is released high.

A source select input chooses what starts a takeover. It can be the onboard port latch, or an external active-low request line driven by another board. Once the request is active, the block raises a hold request toward the bus owner. It waits for the hold acknowledge, which is synchronized through two flip-flops. Only after that does it release the local CPU and enable its bus drivers.

When the request is withdrawn, the CPU is stopped but the drivers stay on until the CPU's current cycle ends. The drivers are then switched off, and in the following cycle the hold request is dropped so that the previous owner resumes. A strap input selects master mode instead. In master mode the board owns the bus straight from reset, with no handshake.

Top module: `tmx_bus_takeover`

## Requirements
- R1: In slave mode (cfg_master=0), reset leaves tm_req_n=1, hold_req=0, cpu_ready=0, all drv_en bits 0 and bus_owned=0.
- R2: In master mode (cfg_master=1), cpu_ready=1, every drv_en bit 1, bus_owned=1 and hold_req=0 from reset onward. Port writes, ext_req_n and hold_ack do not change these outputs.
- R3: A write (io_wr_stb=1) with io_wr_addr equal to cfg_port_addr sets tm_req_n to 0 on the next clock edge if data bit io_wr_data[cfg_bit_sel] equals cfg_act_level. It sets tm_req_n to 1 if that bit differs from cfg_act_level.
- R4: A write to any other address leaves tm_req_n unchanged.
- R5: With cfg_src_ext=0 the takeover request is the inverse of tm_req_n. With cfg_src_ext=1 it is the inverse of ext_req_n after a two-flip-flop synchronizer, and port writes start no takeover.
- R6: On a request, hold_req rises while cpu_ready, drv_en and bus_owned stay 0. These outputs turn on only at the third rising clock edge after hold_ack rises, because hold_ack passes through two synchronizer flip-flops and the state register.
- R7: A new hold request is not raised while the synchronized hold_ack is still high.
- R8: When the request is withdrawn while the board owns the bus, cpu_ready drops at once. drv_en and bus_owned stay on while cpu_cycle_busy=1. Once cpu_cycle_busy is 0, the drivers turn off for one cycle with hold_req still high, and then hold_req drops.
- R9: If the request is withdrawn before the acknowledge arrives, hold_req drops and the drivers are never enabled.
- R10: In slave mode bus_owned is 1 exactly while the drivers are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | Strap: 1 = owns the bus from reset, 0 = dormant until handed the bus |
| cfg_src_ext | input | 1 | Request source: 0 = port latch, 1 = external line |
| cfg_port_addr | input | 8 | Address of the activation port |
| cfg_bit_sel | input | 3 | Index of the sampled data bit |
| cfg_act_level | input | 1 | Bit value that activates the request |
| io_wr_stb | input | 1 | Port write strobe from the current bus owner |
| io_wr_addr | input | 8 | Port write address |
| io_wr_data | input | 8 | Port write data |
| ext_req_n | input | 1 | External active-low takeover request (asynchronous) |
| hold_ack | input | 1 | Hold acknowledge from the bus owner (asynchronous) |
| cpu_cycle_busy | input | 1 | Local CPU is in the middle of a bus cycle |
| tm_req_n | output | 1 | Latched port request, low when active |
| hold_req | output | 1 | Hold request toward the bus owner |
| cpu_ready | output | 1 | Local CPU released to run |
| drv_en | output | 4 | Enables for the local bus driver groups |
| bus_owned | output | 1 | Indicator: this board owns the bus |

## Verification
The hardest situation to reach is a new activation that arrives while the previous owner still holds its acknowledge high after a handover. The bench creates it by keeping hold_ack asserted through a full release and then writing the activating value again. It checks that hold_req stays low for several cycles and rises only after hold_ack falls. The drain case is reached by holding cpu_cycle_busy high across the release write, so that the drivers must stay on with the CPU stopped. The scoreboard predicts every change of the output bundle in order, so a skipped or extra intermediate state is reported.

// File: rtl/tmx_pkg.sv
`timescale 1ns/1ps
package tmx_pkg;

   typedef enum logic [2:0] {
      ST_MASTER  = 3'd0,
      ST_DORMANT = 3'd1,
      ST_REQUEST = 3'd2,
      ST_OWNED   = 3'd3,
      ST_DRAIN   = 3'd4,
      ST_RETIRE  = 3'd5
   } hand_state_e;

   typedef struct packed {
      logic hold;
      logic run;
      logic drive;
      logic lamp;
   } bus_ctl_t;

   function automatic bus_ctl_t ctl_of(hand_state_e st);
      bus_ctl_t c;
      case (st)
         ST_MASTER:  c = '{hold: 1'b0, run: 1'b1, drive: 1'b1, lamp: 1'b1};
         ST_REQUEST: c = '{hold: 1'b1, run: 1'b0, drive: 1'b0, lamp: 1'b0};
         ST_OWNED:   c = '{hold: 1'b1, run: 1'b1, drive: 1'b1, lamp: 1'b1};
         ST_DRAIN:   c = '{hold: 1'b1, run: 1'b0, drive: 1'b1, lamp: 1'b1};
         ST_RETIRE:  c = '{hold: 1'b1, run: 1'b0, drive: 1'b0, lamp: 1'b0};
         default:    c = '{hold: 1'b0, run: 1'b0, drive: 1'b0, lamp: 1'b0};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tmx_sync.sv
`timescale 1ns/1ps
module tmx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("tmx_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tmx_port_latch.sv
`timescale 1ns/1ps
module tmx_port_latch #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   localparam int BSEL_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_port_addr,
   input  logic [BSEL_W-1:0] cfg_bit_sel,
   input  logic              cfg_act_level,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              req_n
);
   logic hit;
   logic sampled;

   initial begin
      assert (DATA_W >= 2 && (DATA_W & (DATA_W - 1)) == 0)
         else $error("tmx_port_latch: DATA_W must be a power of two");
      assert (ADDR_W >= 1) else $error("tmx_port_latch: ADDR_W must be positive");
   end

   assign hit     = wr_stb && (wr_addr == cfg_port_addr);
   assign sampled = wr_data[cfg_bit_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   req_n <= 1'b1;
      else if (hit) req_n <= sampled ^ cfg_act_level;
   end

   AST_PORT_ACTIVATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == cfg_port_addr && wr_data[cfg_bit_sel] == cfg_act_level) |=> !req_n); // R3
   AST_PORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == cfg_port_addr && wr_data[cfg_bit_sel] != cfg_act_level) |=> req_n); // R3
   AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr != cfg_port_addr) |=> $stable(req_n)); // R4
endmodule

// File: rtl/tmx_handover_fsm.sv
`timescale 1ns/1ps
module tmx_handover_fsm
   import tmx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_master,
   input  logic     want,
   input  logic     ack_s,
   input  logic     cpu_busy,
   output bus_ctl_t ctl
);
   hand_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         ST_MASTER:  state_nx = ST_MASTER;
         ST_DORMANT: if (want && !ack_s) state_nx = ST_REQUEST;
         ST_REQUEST: begin
            if (!want)      state_nx = ST_DORMANT;
            else if (ack_s) state_nx = ST_OWNED;
         end
         ST_OWNED:   if (!want) state_nx = ST_DRAIN;
         ST_DRAIN:   if (!cpu_busy) state_nx = ST_RETIRE;
         ST_RETIRE:  state_nx = ST_DORMANT;
         default:    state_nx = ST_DORMANT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= cfg_master ? ST_MASTER : ST_DORMANT;
      else        state <= state_nx;
   end

   assign ctl = ctl_of(state);

   AST_MASTER_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_master |-> (!ctl.hold && ctl.run && ctl.drive)); // R2
   AST_RUN_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctl.run) && !cfg_master) |-> $past(ack_s)); // R6
   AST_NO_STALE_ACK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctl.hold) && !cfg_master) |-> !$past(ack_s)); // R7
   AST_DRAIN_KEEPS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN && cpu_busy) |=> (ctl.drive && !ctl.run)); // R8
   AST_HOLD_DROP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl.hold) && !cfg_master) |-> !$past(ctl.drive)); // R8
   AST_ABORT_NO_DRV: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REQUEST && !want) |=> !ctl.drive); // R9
endmodule

// File: rtl/tmx_bus_takeover.sv
`timescale 1ns/1ps
module tmx_bus_takeover
   import tmx_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int DRV_W        = 4,
   parameter int SYNC_STAGES  = 2,
   parameter bit EXT_REQ_SYNC = 1'b1,
   localparam int BSEL_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_src_ext,
   input  logic [ADDR_W-1:0] cfg_port_addr,
   input  logic [BSEL_W-1:0] cfg_bit_sel,
   input  logic              cfg_act_level,
   input  logic              io_wr_stb,
   input  logic [ADDR_W-1:0] io_wr_addr,
   input  logic [DATA_W-1:0] io_wr_data,
   input  logic              ext_req_n,
   input  logic              hold_ack,
   input  logic              cpu_cycle_busy,
   output logic              tm_req_n,
   output logic              hold_req,
   output logic              cpu_ready,
   output logic [DRV_W-1:0]  drv_en,
   output logic              bus_owned
);
   logic     port_req_n;
   logic     ext_req_s_n;
   logic     ack_s;
   logic     want;
   bus_ctl_t ctl;

   initial begin
      assert (DRV_W >= 1) else $error("tmx_bus_takeover: DRV_W must be positive");
      assert (SYNC_STAGES >= 2) else $error("tmx_bus_takeover: SYNC_STAGES must be at least 2");
   end

   tmx_port_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .cfg_port_addr(cfg_port_addr), .cfg_bit_sel(cfg_bit_sel),
      .cfg_act_level(cfg_act_level),
      .wr_stb(io_wr_stb), .wr_addr(io_wr_addr), .wr_data(io_wr_data),
      .req_n(port_req_n)
   );

   tmx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(hold_ack), .q(ack_s)
   );

   if (EXT_REQ_SYNC) begin : g_ext_sync
      tmx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
         .clk(clk), .rst_n(rst_n), .d(ext_req_n), .q(ext_req_s_n)
      );
   end else begin : g_ext_direct
      assign ext_req_s_n = ext_req_n;
   end

   assign want = cfg_src_ext ? !ext_req_s_n : !port_req_n;

   tmx_handover_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
      .want(want), .ack_s(ack_s), .cpu_busy(cpu_cycle_busy), .ctl(ctl)
   );

   for (genvar g = 0; g < DRV_W; g++) begin : g_drv
      assign drv_en[g] = ctl.drive;
   end

   assign tm_req_n  = port_req_n;
   assign hold_req  = ctl.hold;
   assign cpu_ready = ctl.run;
   assign bus_owned = ctl.lamp;

   AST_LAMP_WITH_DRV: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> (bus_owned == (&drv_en))); // R10
   AST_EXT_BLOCKS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src_ext && !cfg_master && ext_req_s_n && !hold_req) |=> !hold_req); // R5
endmodule

// File: tb/tmx_bus_takeover_test.sv
`timescale 1ns/1ps
module tmx_bus_takeover_test;
   localparam int DRV_W = 4;
   localparam int TW    = DRV_W + 4;
   typedef logic [TW-1:0] tup_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_master = 1'b0, cfg_src_ext = 1'b0, cfg_act_level = 1'b0;
   logic [7:0] cfg_port_addr = 8'h99;
   logic [2:0] cfg_bit_sel = 3'd0;
   logic io_wr_stb = 1'b0;
   logic [7:0] io_wr_addr = '0, io_wr_data = '0;
   logic ext_req_n = 1'b1, hold_ack = 1'b0, cpu_cycle_busy = 1'b0;
   logic tm_req_n, hold_req, cpu_ready, bus_owned;
   logic [DRV_W-1:0] drv_en;

   int n_chk = 0, n_err = 0, cyc = 0;
   bit mon_on = 0, resync = 0;
   tup_t prev;
   tup_t exp_q[$];
   string tag_q[$];

   tmx_bus_takeover #(.ADDR_W(8), .DATA_W(8), .DRV_W(DRV_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_src_ext(cfg_src_ext),
      .cfg_port_addr(cfg_port_addr), .cfg_bit_sel(cfg_bit_sel), .cfg_act_level(cfg_act_level),
      .io_wr_stb(io_wr_stb), .io_wr_addr(io_wr_addr), .io_wr_data(io_wr_data),
      .ext_req_n(ext_req_n), .hold_ack(hold_ack), .cpu_cycle_busy(cpu_cycle_busy),
      .tm_req_n(tm_req_n), .hold_req(hold_req), .cpu_ready(cpu_ready),
      .drv_en(drv_en), .bus_owned(bus_owned)
   );

   always #2.5 clk = ~clk;

   function automatic tup_t mk(bit rq, bit h, bit r, bit d, bit l);
      return {rq, h, r, {DRV_W{d}}, l};
   endfunction

   function automatic tup_t cur_t();
      return {tm_req_n, hold_req, cpu_ready, drv_en, bus_owned};
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic push(tup_t t, string tag);
      exp_q.push_back(t);
      tag_q.push_back(tag);
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Monitor: every change of the output bundle must match the next predicted item
   always @(negedge clk) begin
      if (mon_on) begin
         tup_t c;
         c = cur_t();
         if (resync || c != prev) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "unexpected output change", 32'(c), 32'(prev));
            end else begin
               tup_t e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(c == e, t, 32'(c), 32'(e));
            end
            resync = 0;
         end
         prev = c;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_err++;
         $display("FAIL watchdog: actual %0d expected below 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic do_reset(bit m, bit ext, logic [7:0] addr, logic [2:0] sel, bit lvl, tup_t e, string tag);
      mon_on = 0;
      rst_n = 0;
      cfg_master = m; cfg_src_ext = ext; cfg_port_addr = addr;
      cfg_bit_sel = sel; cfg_act_level = lvl;
      ext_req_n = 1; hold_ack = 0; cpu_cycle_busy = 0; io_wr_stb = 0;
      tick(3);
      rst_n = 1;
      push(e, tag);
      resync = 1;
      mon_on = 1;
      tick(2);
      check(cur_t() == e, tag, 32'(cur_t()), 32'(e));
   endtask

   task automatic port_write(logic [7:0] a, logic [7:0] d);
      io_wr_addr = a; io_wr_data = d; io_wr_stb = 1;
      tick(1);
      io_wr_stb = 0;
   endtask

   initial begin
      tick(1);
      // Slave mode, port source, address 99h, bit 3, active level 0
      do_reset(0, 0, 8'h99, 3'd3, 0, mk(1,0,0,0,0), "R1 slave reset state");
      port_write(8'h98, 8'h00);
      tick(3);
      check(tm_req_n == 1 && hold_req == 0, "R4 other address ignored", {tm_req_n, hold_req}, 2'b10);
      push(mk(0,0,0,0,0), "R3 activating bit pulls request low");
      push(mk(0,1,0,0,0), "R6 hold request raised");
      port_write(8'h99, 8'hF7);
      tick(4);
      check(drv_en == 0 && cpu_ready == 0, "R6 no drive before ack", {drv_en, cpu_ready}, 0);
      push(mk(0,1,1,1,1), "R6 owned after ack");
      hold_ack = 1;
      tick(1);
      check(drv_en == 0, "R6 drivers off one edge after ack", drv_en, 0);
      tick(1);
      check(drv_en == 0, "R6 drivers off two edges after ack", drv_en, 0);
      tick(1);
      check(&drv_en && bus_owned, "R6 drivers on three edges after ack", {drv_en, bus_owned}, {{DRV_W{1'b1}}, 1'b1});
      // Release while the CPU is mid-cycle
      cpu_cycle_busy = 1;
      push(mk(1,1,1,1,1), "R3 opposite bit releases request");
      push(mk(1,1,0,1,1), "R8 drain: cpu stopped, drivers kept");
      port_write(8'h99, 8'h08);
      tick(4);
      check(&drv_en && !cpu_ready && hold_req, "R8 drivers held while busy", {drv_en, cpu_ready, hold_req}, {{DRV_W{1'b1}}, 2'b01});
      push(mk(1,1,0,0,0), "R8 drivers off before hold drops");
      push(mk(1,0,0,0,0), "R8 hold dropped");
      cpu_cycle_busy = 0;
      tick(4);
      // Acknowledge still high: new request must wait
      push(mk(0,0,0,0,0), "R3 reactivate");
      port_write(8'h99, 8'h00);
      tick(6);
      check(hold_req == 0, "R7 no hold while ack still high", hold_req, 0);
      push(mk(0,1,0,0,0), "R7 hold after ack falls");
      hold_ack = 0;
      tick(5);
      // Abort before acknowledge
      push(mk(1,1,0,0,0), "R9 request withdrawn");
      push(mk(1,0,0,0,0), "R9 hold dropped without drive");
      port_write(8'h99, 8'h08);
      tick(4);

      // Active level 1, bit 7, address 3Ch
      do_reset(0, 0, 8'h3C, 3'd7, 1, mk(1,0,0,0,0), "R1 slave reset state again");
      port_write(8'h99, 8'h80);
      tick(3);
      check(tm_req_n == 1, "R4 old address now ignored", tm_req_n, 1);
      push(mk(0,0,0,0,0), "R3 active level 1 on bit 7");
      push(mk(0,1,0,0,0), "R6 hold raised");
      port_write(8'h3C, 8'h80);
      tick(3);
      push(mk(0,1,1,1,1), "R10 owned with indicator");
      hold_ack = 1;
      tick(5);
      push(mk(1,1,1,1,1), "R3 level 1 release");
      push(mk(1,1,0,1,1), "R8 drain one cycle");
      push(mk(1,1,0,0,0), "R8 retire");
      push(mk(1,0,0,0,0), "R8 dormant");
      port_write(8'h3C, 8'h7F);
      tick(5);
      hold_ack = 0;
      tick(3);

      // External request source
      do_reset(0, 1, 8'h99, 3'd0, 0, mk(1,0,0,0,0), "R1 reset with external source");
      push(mk(0,0,0,0,0), "R5 port latch still updates");
      port_write(8'h99, 8'h00);
      tick(6);
      check(hold_req == 0, "R5 port write starts no takeover", hold_req, 0);
      push(mk(0,1,0,0,0), "R5 external request raises hold");
      ext_req_n = 0;
      tick(5);
      push(mk(0,1,1,1,1), "R5 external takeover owned");
      hold_ack = 1;
      tick(5);
      push(mk(0,1,0,1,1), "R5 external withdraw drains");
      push(mk(0,1,0,0,0), "R8 retire");
      push(mk(0,0,0,0,0), "R8 dormant");
      ext_req_n = 1;
      tick(8);
      hold_ack = 0;
      tick(3);

      // Master mode
      do_reset(1, 0, 8'h99, 3'd0, 0, mk(1,0,1,1,1), "R2 master active from reset");
      push(mk(0,0,1,1,1), "R2 port write leaves master outputs");
      port_write(8'h99, 8'h00);
      hold_ack = 1; ext_req_n = 0;
      tick(8);
      check(cur_t() == mk(0,0,1,1,1), "R2 master ignores ack and request", 32'(cur_t()), 32'(mk(0,0,1,1,1)));
      push(mk(1,0,1,1,1), "R2 release write in master mode");
      port_write(8'h99, 8'h01);
      tick(5);

      check(exp_q.size() == 0, "all predicted changes seen", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule